// File: doc/BRIEF.md
# Dual Comparator Control and Interrupt Unit

This block is the digital side of a pair of analog voltage comparators. Each channel owns one byte-wide control/status register on a small CPU register bus. The register drives the enable and input-select lines of its analog comparator and gates the raw comparator result onto an output pin. It also holds the comparator result, synchronized into the CPU clock domain, and a sticky change flag. A single registered interrupt request is raised when either flag is set and a global interrupt enable is high.

A freshly enabled comparator needs time to settle. For a parameterized number of clock cycles after its enable goes high, and at all times while it is disabled, result changes do not set the flag. The change-detect history keeps tracking the synchronized result, so a change during settling does not raise the flag later either. The pin path bypasses the synchronizer and is purely combinational.

Top module: `dual_cmp_ctrl`

## Requirements
- R1: After reset every channel register reads 0x00, and `ena_o`, `pos_sel_o`, `neg_sel_o`, `pin_o` and `irq_o` are all 0.
- R2: Channel i sits at address `BASE_ADDR+i` (defaults: 0xC and 0xD). A write there loads bit 5 into the enable, bit 4 into the positive select (0 = input A, 1 = input B), bit 3 into the negative select (0 = external reference, 1 = internal reference) and bit 2 into the output enable. These bits read back in place and appear on `ena_o`, `pos_sel_o`, `neg_sel_o` from the next cycle. Other addresses read 0x00 and writes to them change nothing.
- R3: Read bit 1 is the raw comparator input after a two-flop synchronizer. It reflects a change of `cmp_raw_i` after the second rising edge. Writes to bit 1 have no effect. The result tracks the input even while the channel is disabled.
- R4: Read bit 0 (flag) goes to 1 one cycle after the synchronized result changes in either direction, while the channel is armed. Writing 0 to bit 0 clears it. Writing 1 leaves it unchanged.
- R5: While the channel is disabled, and for SETTLE_CYC cycles after enable is written to 1, result changes never set the flag, either then or afterwards. A synchronized change compared on the edge just after the window sets the flag. One compared on the last window edge does not.
- R6: If a result change and a clearing write hit the flag on the same edge, the flag ends up 1.
- R7: `irq_o` is a register loaded each cycle with (flag of channel 0 OR flag of channel 1) AND `irq_en_i`.
- R8: `pin_o[i]` equals `cmp_raw_i[i]` combinationally when enable and output enable are both 1, and is 0 otherwise.
- R9: Register bits 7:6 always read 0, even after being written with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| irq_en_i | input | 1 | Global comparator interrupt enable |
| cmp_raw_i | input | N_CH | Raw analog comparator outputs |
| ena_o | output | N_CH | Comparator enable to analog |
| pos_sel_o | output | N_CH | Positive-input select (0 = A, 1 = B) |
| neg_sel_o | output | N_CH | Negative-input select (0 = external ref, 1 = internal ref) |
| pin_o | output | N_CH | Gated raw result to output pin |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is the exact edge of the settling window. A result change must be compared either on the last cycle of the window or on the first cycle after it. The bench counts negative edges from the enabling write, then moves the raw input so that the two synchronizer stages carry the change onto the chosen comparison edge. Both alignments are run from reset. A second hard case is a clearing write that lands on the same edge as a hardware flag set. The bench issues the write exactly two cycles after moving the raw input.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int REG_W = 8;
  // bit positions decoded by software
  localparam int FLAG_B = 0;
  localparam int RES_B  = 1;
  localparam int OE_B   = 2;
  localparam int NEG_B  = 3;
  localparam int POS_B  = 4;
  localparam int EN_B   = 5;

  typedef struct packed {
    logic en;
    logic pos_sel;
    logic neg_sel;
    logic oe;
  } cmp_cfg_t;
endpackage

// File: rtl/cmpu_sync.sv
module cmpu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmpu_settle.sv
module cmpu_settle #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic armed_o
);
  localparam int CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  // reload while disabled, count down once enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= LOAD;
    else if (!en_i)           cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign armed_o = en_i && (cnt_q == '0);

  // R5
  generate
    if (CYCLES > 0) begin : g_chk
      settle_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i ##1 en_i) |-> !armed_o);
    end
  endgenerate
endmodule

// File: rtl/cmpu_channel.sv
module cmpu_channel
  import cmpu_pkg::*;
#(
  parameter int SETTLE_CYC  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             raw_i,
  output logic             ena_o,
  output logic             pos_sel_o,
  output logic             neg_sel_o,
  output logic             pin_o,
  output logic             flag_o
);
  cmp_cfg_t cfg_q;
  logic     res_s, hist_q, flag_q, armed, set_flag, clr_flag;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata_i[REG_W-1:EN_B+1], wdata_i[RES_B]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_i) begin
      cfg_q.en      <= wdata_i[EN_B];
      cfg_q.pos_sel <= wdata_i[POS_B];
      cfg_q.neg_sel <= wdata_i[NEG_B];
      cfg_q.oe      <= wdata_i[OE_B];
    end
  end

  cmpu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (res_s)
  );

  cmpu_settle #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_q.en),
    .armed_o(armed)
  );

  // history always follows result, so suppressed changes are absorbed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= res_s;
  end

  assign set_flag = armed && (res_s != hist_q);
  assign clr_flag = wr_i && !wdata_i[FLAG_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (set_flag) flag_q <= 1'b1;   // set beats clear
    else if (clr_flag) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o         = '0;
    rdata_o[FLAG_B] = flag_q;
    rdata_o[RES_B]  = res_s;
    rdata_o[OE_B]   = cfg_q.oe;
    rdata_o[NEG_B]  = cfg_q.neg_sel;
    rdata_o[POS_B]  = cfg_q.pos_sel;
    rdata_o[EN_B]   = cfg_q.en;
  end

  assign ena_o     = cfg_q.en;
  assign pos_sel_o = cfg_q.pos_sel;
  assign neg_sel_o = cfg_q.neg_sel;
  assign pin_o     = raw_i && cfg_q.en && cfg_q.oe;
  assign flag_o    = flag_q;

  // R2
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ena_o == $past(wdata_i[EN_B])) && (pos_sel_o == $past(wdata_i[POS_B])));

  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_flag) |=> flag_q);

  // R5
  flag_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !flag_q) |=> !flag_q);

  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flag && clr_flag) |=> flag_q);
endmodule

// File: rtl/dual_cmp_ctrl.sv
module dual_cmp_ctrl
  import cmpu_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int BASE_ADDR   = 12,
  parameter int N_CH        = 2,
  parameter int SETTLE_CYC  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              irq_en_i,
  input  logic [N_CH-1:0]   cmp_raw_i,
  output logic [N_CH-1:0]   ena_o,
  output logic [N_CH-1:0]   pos_sel_o,
  output logic [N_CH-1:0]   neg_sel_o,
  output logic [N_CH-1:0]   pin_o,
  output logic              irq_o
);
  logic [N_CH-1:0]  hit, flags;
  logic [REG_W-1:0] ch_rd [N_CH];
  logic             irq_q;

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(BASE_ADDR + i);
      assign hit[i] = (addr_i == CH_ADDR);

      cmpu_channel #(
        .SETTLE_CYC (SETTLE_CYC),
        .SYNC_STAGES(SYNC_STAGES)
      ) u_ch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (we_i && hit[i]),
        .wdata_i  (wdata_i),
        .rdata_o  (ch_rd[i]),
        .raw_i    (cmp_raw_i[i]),
        .ena_o    (ena_o[i]),
        .pos_sel_o(pos_sel_o[i]),
        .neg_sel_o(neg_sel_o[i]),
        .pin_o    (pin_o[i]),
        .flag_o   (flags[i])
      );
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++)
      if (hit[i]) rdata_o = rdata_o | ch_rd[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_en_i && (|flags);
  end

  assign irq_o = irq_q;

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && (|flags)) |=> irq_o);

  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:EN_B+1] == '0);
endmodule

// File: tb/sim_dual_cmp_ctrl.sv
module sim_dual_cmp_ctrl;
  localparam int CLK_P = 10;
  localparam int S     = 8;
  localparam logic [3:0] A0 = 4'hC, A1 = 4'hD, AX = 4'h3;

  logic       clk = 0, rst_ni = 0, we = 0, irq_en = 0;
  logic [3:0] addr = A0;
  logic [7:0] wdata = 0, rdata;
  logic [1:0] raw = 0, ena, pos, neg, pin;
  logic       irq;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_cmp_ctrl #(.SETTLE_CYC(S)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_en_i(irq_en), .cmp_raw_i(raw), .ena_o(ena),
    .pos_sel_o(pos), .neg_sel_o(neg), .pin_o(pin), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; we = 0; raw = 0; irq_en = 0;
    cyc(2);
    rst_ni = 1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(A0, d); chk("R1 reg0", d, 8'h00);
    rd(A1, d); chk("R1 reg1", d, 8'h00);
    chk("R1 outs", {ena, pos, neg, pin}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] d;
    do_reset();
    wr(A0, 8'h3D);
    rd(A0, d); chk("R2 readback", d, 8'h3C);
    chk("R2 outs", {ena, pos, neg}, 6'b01_01_01);
    wr(A1, 8'h11);
    rd(A1, d); chk("R2 ch1", d, 8'h10);
    chk("R2 ch1 outs", {ena, pos, neg}, 6'b01_11_01);
    wr(AX, 8'h3D);
    rd(AX, d); chk("R2 bad addr read", d, 8'h00);
    rd(A1, d); chk("R2 bad addr write", d, 8'h10);
    wr(A0, 8'hD3);
    rd(A0, d); chk("R9 rsvd", d, 8'h10);
  endtask

  task automatic settle0();
    do_reset();
    wr(A0, 8'h21);
    cyc(S + 4);
  endtask

  task automatic t_sync_flag();
    logic [7:0] d;
    settle0();
    raw[0] = 1;
    cyc(1); rd(A0, d); chk("R3 one edge", d, 8'h20);
    cyc(1); rd(A0, d); chk("R3 two edges", d, 8'h22);
    wr(A0, 8'h21);
    rd(A0, d); chk("R4 rise flag", d, 8'h23);
    wr(A0, 8'h23);
    rd(A0, d); chk("R4 write one keeps", d, 8'h23);
    wr(A0, 8'h20);
    rd(A0, d); chk("R4 clear", d, 8'h22);
    raw[0] = 0;
    cyc(2); rd(A0, d); chk("R4 not yet", d, 8'h20);
    cyc(1); rd(A0, d); chk("R4 fall flag", d, 8'h21);
  endtask

  task automatic t_settle();
    logic [7:0] d;
    do_reset();
    raw[0] = 1;
    cyc(5); rd(A0, d); chk("R5 disabled R3 tracks", d, 8'h02);
    do_reset();
    wr(A0, 8'h21);
    raw[0] = 1;
    cyc(S + 4); rd(A0, d); chk("R5 change in window", d, 8'h22);
    // compared on last window edge: no flag
    do_reset();
    wr(A0, 8'h21);
    cyc(S - 3); raw[0] = 1;
    cyc(6); rd(A0, d); chk("R5 last window edge", d, 8'h22);
    // compared on first armed edge: flag
    do_reset();
    wr(A0, 8'h21);
    cyc(S - 2); raw[0] = 1;
    cyc(6); rd(A0, d); chk("R5 first armed edge", d, 8'h23);
  endtask

  task automatic t_race();
    logic [7:0] d;
    settle0();
    raw[0] = 1;
    cyc(2);
    wr(A0, 8'h20);
    rd(A0, d); chk("R6 set wins", d, 8'h23);
    wr(A0, 8'h20);
    rd(A0, d); chk("R6 later clear", d, 8'h22);
  endtask

  task automatic t_irq();
    do_reset();
    wr(A1, 8'h21);
    cyc(S + 4);
    raw[1] = 1;
    cyc(4); chk("R7 gated off", {7'd0, irq}, 8'h00);
    irq_en = 1;
    #1; chk("R7 registered", {7'd0, irq}, 8'h00);
    cyc(1); chk("R7 raised", {7'd0, irq}, 8'h01);
    wr(A1, 8'h20);
    chk("R7 one-cycle lag", {7'd0, irq}, 8'h01);
    cyc(1); chk("R7 dropped", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_pin();
    do_reset();
    wr(A0, 8'h25);
    raw[0] = 1;
    #1; chk("R8 pass", {6'd0, pin}, 8'h01);
    raw[0] = 0;
    #1; chk("R8 follows", {6'd0, pin}, 8'h00);
    raw = 2'b11;
    wr(A0, 8'h21);
    chk("R8 oe off", {6'd0, pin}, 8'h00);
    wr(A0, 8'h05);
    chk("R8 en off", {6'd0, pin}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_config();
    t_sync_flag();
    t_settle();
    t_race();
    t_irq();
    t_pin();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule